// File: doc/BRIEF.md
# Top-Three Momentum Candidate Selector

Every crossing, this block takes eight muon candidates. They come from four detector quarters, with two candidates from each quarter. It returns the three candidates with the highest transverse momentum, ranked from highest to lowest. With each selected candidate it also returns that candidate's input position and its address field, which passes through unchanged. It also outputs the sum of the two highest momenta, one bit wider than a momentum so that the sum cannot overflow.

The logic is a synchronous pipeline that accepts a complete set of eight candidates on every clock, so later trigger logic can apply thresholds to the result without any stall. The first stage orders the two candidates inside each quarter. A tree of merge stages then keeps the best three at each level. A final register adds up the top two. A crossing number and a valid flag travel through the pipeline alongside the data, so every result can be matched with the input set it came from. With the default four quarters the latency is fixed at four clocks.

Top module: `mu_top3_select`

## Requirements
- R1: While `rst_n` is low at a rising clock edge (synchronous, active-low reset), the pipeline is cleared. `out_valid` and all output data are zero, and no result appears in the four cycles after release unless an input set was offered.
- R2: Slot 0 (bits [6:0] of `out_pt`) carries the highest momentum among the eight candidates of the set.
- R3: Slots 1 and 2 (`out_pt` bits [13:7] and [20:14]) carry the second and third highest momenta, so slot momenta never increase from slot 0 to slot 2.
- R4: Each slot's `out_idx` field (3 bits per slot, same slot order) gives the input position of the candidate in that slot. Position k is candidate k on `in_pt`, and quarter q owns positions 2q and 2q+1. When momenta are equal, the lower position is ranked first, and the three positions are always distinct.
- R5: `out_sum` equals slot 0 plus slot 1 momentum as an 8-bit value, which reaches 254 without wrapping.
- R6: Results appear exactly four clocks after their set is sampled. One set is accepted every clock, and `out_bx` returns the crossing number given with that set.
- R7: `out_valid` repeats `in_valid` four clocks later. A clock with `in_valid` low produces `out_valid` low in its output cycle.
- R8: The 6-bit address of each selected candidate (`out_addr`, 6 bits per slot) is the address given with that candidate on `in_addr` at position k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | The candidate set on this clock is real |
| in_bx | input | 12 | Crossing number of this set |
| in_pt | input | 56 | Eight 7-bit momenta, candidate k at bits [7k+6:7k] |
| in_addr | input | 48 | Eight 6-bit addresses, candidate k at bits [6k+5:6k] |
| out_valid | output | 1 | Output slots hold a result |
| out_bx | output | 12 | Crossing number of the result |
| out_pt | output | 21 | Three ranked momenta, slot 0 in the low bits |
| out_idx | output | 9 | Input positions of the three slots |
| out_addr | output | 18 | Addresses of the three slots |
| out_sum | output | 8 | Sum of slot 0 and slot 1 momenta |

## Verification
Tie resolution and the widest possible sum can both be needed in the same cycle. This happens when two or more candidates share the maximum momentum of 127: the block must then order them by position and also output 254 without wrapping. A sweep over every assignment of the values {0, 1, 64, 127} to the eight candidates creates these collisions in many arrangements, including ties that span quarters and ties inside a quarter. After that sweep, pseudo-random sets with narrowed momentum ranges force ties among low values. The bench checks slot order, positions, addresses and the sum against a plain selection by repeated maximum search. Stall cycles inserted at irregular intervals test the valid and crossing-number alignment.

// File: rtl/mu_sel_pkg.sv
// Shared widths, candidate record and ranking rule for the top-three selector.
package mu_sel_pkg;
    localparam int PT_W   = 7;   // momentum field width
    localparam int IDX_W  = 3;   // input position width
    localparam int ADDR_W = 6;   // candidate address width
    localparam int NSEL   = 3;   // number of ranked output slots
    localparam int SUM_W  = PT_W + 1;

    typedef struct packed {
        logic              vld;
        logic [PT_W-1:0]   pt;
        logic [IDX_W-1:0]  idx;
        logic [ADDR_W-1:0] addr;
    } cand_t;

    // True when a must be ranked ahead of b: valid first, then higher pt, then lower index.
    function automatic logic outranks(input cand_t a, input cand_t b);
        return a.vld && (!b.vld || (a.pt > b.pt) || ((a.pt == b.pt) && (a.idx < b.idx)));
    endfunction
endpackage

// File: rtl/mu_pair_sort.sv
// Orders the two candidates of one quarter into a ranked list of NSEL entries.
// Assumes: purely combinational; entries past the second are padded invalid.
module mu_pair_sort
    import mu_sel_pkg::*;
(
    input  cand_t cand_a,
    input  cand_t cand_b,
    output cand_t ranked [NSEL]
);
    // Place the stronger candidate first and pad the remainder.
    always_comb begin
        for (int k = 0; k < NSEL; k++) ranked[k] = '0;
        if (outranks(cand_b, cand_a)) begin
            ranked[0] = cand_b;
            ranked[1] = cand_a;
        end else begin
            ranked[0] = cand_a;
            ranked[1] = cand_b;
        end
    end
endmodule

// File: rtl/mu_top3_merge.sv
// Merges two ranked lists of NSEL entries and keeps the best NSEL.
// Assumes: both inputs ranked by outranks(); invalid entries sit at the tail.
// Since the k-th pick has consumed k entries in total, neither read pointer
// can pass NSEL-1 and no bounds test is needed.
module mu_top3_merge
    import mu_sel_pkg::*;
(
    input  cand_t list_a [NSEL],
    input  cand_t list_b [NSEL],
    output cand_t merged [NSEL]
);
    // Two-pointer merge, unrolled over the NSEL output slots.
    always_comb begin
        int ia;
        int ib;
        ia = 0;
        ib = 0;
        for (int k = 0; k < NSEL; k++) begin
            if (outranks(list_b[ib], list_a[ia])) begin
                merged[k] = list_b[ib];
                ib = ib + 1;
            end else begin
                merged[k] = list_a[ia];
                ia = ia + 1;
            end
        end
    end
endmodule

// File: rtl/mu_top3_select.sv
// Top-three momentum selector: ranks N_QUAD*2 candidates per clock and
// returns the best three plus the sum of the two highest momenta.
// Assumes: N_QUAD is a power of two, at least 2, and N_QUAD*2 fits IDX_W.
// Latency is 2 + log2(N_QUAD) clocks (pair stage, merge levels, output stage).
module mu_top3_select
    import mu_sel_pkg::*;
#(
    parameter int N_QUAD = 4,
    parameter int BX_W   = 12
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [BX_W-1:0]           in_bx,
    input  logic [N_QUAD*2*PT_W-1:0]  in_pt,
    input  logic [N_QUAD*2*ADDR_W-1:0] in_addr,
    output logic                      out_valid,
    output logic [BX_W-1:0]           out_bx,
    output logic [NSEL*PT_W-1:0]      out_pt,
    output logic [NSEL*IDX_W-1:0]     out_idx,
    output logic [NSEL*ADDR_W-1:0]    out_addr,
    output logic [SUM_W-1:0]          out_sum
);
    localparam int N_CAND = N_QUAD * 2;
    localparam int LEVELS = $clog2(N_QUAD);
    localparam int LAT    = LEVELS + 2;
    localparam int N_NODE = 2 * N_QUAD - 1;

    cand_t cin    [N_CAND];
    cand_t leaf_c [N_QUAD][NSEL];
    cand_t node_c [N_QUAD-1][NSEL];
    cand_t tree   [N_NODE][NSEL];   // heap order: node n has children 2n+1, 2n+2

    logic            vpipe [LAT];
    logic [BX_W-1:0] bpipe [LAT];

    // Unpack the flat input buses into candidate records tagged by position.
    for (genvar k = 0; k < N_CAND; k++) begin : g_unpack
        assign cin[k] = '{vld:  1'b1,
                          pt:   in_pt[k*PT_W +: PT_W],
                          idx:  IDX_W'(k),
                          addr: in_addr[k*ADDR_W +: ADDR_W]};
    end

    // Leaf stage: one pair sorter and register per quarter.
    for (genvar q = 0; q < N_QUAD; q++) begin : g_leaf
        mu_pair_sort u_pair (
            .cand_a (cin[2*q]),
            .cand_b (cin[2*q+1]),
            .ranked (leaf_c[q])
        );
        // Register the ordered pair of this quarter.
        always_ff @(posedge clk) begin
            for (int k = 0; k < NSEL; k++)
                tree[N_QUAD-1+q][k] <= rst_n ? leaf_c[q][k] : '0;
        end
    end

    // Merge tree: each internal node keeps the best NSEL of its two children.
    for (genvar n = 0; n < N_QUAD - 1; n++) begin : g_node
        mu_top3_merge u_merge (
            .list_a (tree[2*n+1]),
            .list_b (tree[2*n+2]),
            .merged (node_c[n])
        );
        // Register the merged list of this node.
        always_ff @(posedge clk) begin
            for (int k = 0; k < NSEL; k++)
                tree[n][k] <= rst_n ? node_c[n][k] : '0;
        end
    end

    // Carry the valid flag and crossing number alongside the data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < LAT; s++) begin
                vpipe[s] <= 1'b0;
                bpipe[s] <= '0;
            end
        end else begin
            vpipe[0] <= in_valid;
            bpipe[0] <= in_bx;
            for (int s = 1; s < LAT; s++) begin
                vpipe[s] <= vpipe[s-1];
                bpipe[s] <= bpipe[s-1];
            end
        end
    end

    // Output stage: drive the ranked slots and add the two leading momenta.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_pt   <= '0;
            out_idx  <= '0;
            out_addr <= '0;
            out_sum  <= '0;
        end else begin
            for (int s = 0; s < NSEL; s++) begin
                out_pt[s*PT_W +: PT_W]       <= tree[0][s].vld ? tree[0][s].pt : '0;
                out_idx[s*IDX_W +: IDX_W]    <= tree[0][s].idx;
                out_addr[s*ADDR_W +: ADDR_W] <= tree[0][s].addr;
            end
            out_sum <= SUM_W'(tree[0][0].pt) + SUM_W'(tree[0][1].pt);
        end
    end

    assign out_valid = vpipe[LAT-1];
    assign out_bx    = bpipe[LAT-1];
endmodule

// File: rtl/mu_top3_select_chk.sv
// Property checker for mu_top3_select, attached by bind below.
// Assumes: same parameters as the checked instance; observes ports only.
module mu_top3_select_chk
    import mu_sel_pkg::*;
#(
    parameter int N_QUAD = 4,
    parameter int BX_W   = 12
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       in_valid,
    input logic [BX_W-1:0]            in_bx,
    input logic [N_QUAD*2*PT_W-1:0]   in_pt,
    input logic [N_QUAD*2*ADDR_W-1:0] in_addr,
    input logic                       out_valid,
    input logic [BX_W-1:0]            out_bx,
    input logic [NSEL*PT_W-1:0]       out_pt,
    input logic [NSEL*IDX_W-1:0]      out_idx,
    input logic [NSEL*ADDR_W-1:0]     out_addr,
    input logic [SUM_W-1:0]           out_sum
);
    localparam int LAT = $clog2(N_QUAD) + 2;

    logic [PT_W-1:0]  p0, p1, p2;
    logic [IDX_W-1:0] i0, i1, i2;
    logic [7:0]       settle;

    assign p0 = out_pt[0 +: PT_W];
    assign p1 = out_pt[PT_W +: PT_W];
    assign p2 = out_pt[2*PT_W +: PT_W];
    assign i0 = out_idx[0 +: IDX_W];
    assign i1 = out_idx[IDX_W +: IDX_W];
    assign i2 = out_idx[2*IDX_W +: IDX_W];

    // Count clocks since reset release so history checks never reach before it.
    always_ff @(posedge clk) begin
        if (!rst_n)                settle <= '0;
        else if (settle < 8'(LAT)) settle <= settle + 8'd1;
    end

    a_r3_descending: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (p0 >= p1) && (p1 >= p2));

    a_r4_tie_low_first: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((p0 != p1) || (i0 < i1)) && ((p1 != p2) || (i1 < i2)));

    a_r4_distinct_idx: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (i0 != i1) && (i1 != i2) && (i0 != i2));

    a_r5_sum_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_sum >= SUM_W'(p0)) && (out_sum - SUM_W'(p0) == SUM_W'(p1)));

    a_r7_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
        (settle >= 8'(LAT)) |-> (out_valid == $past(in_valid, LAT)));

    a_r6_bx_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (settle >= 8'(LAT)) && out_valid |-> (out_bx == $past(in_bx, LAT)));

    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (settle < 8'(LAT)) |-> !out_valid);
endmodule

bind mu_top3_select mu_top3_select_chk #(.N_QUAD(N_QUAD), .BX_W(BX_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_bx    (in_bx),
    .in_pt    (in_pt),
    .in_addr  (in_addr),
    .out_valid(out_valid),
    .out_bx   (out_bx),
    .out_pt   (out_pt),
    .out_idx  (out_idx),
    .out_addr (out_addr),
    .out_sum  (out_sum)
);

// File: tb/mu_top3_select_test.sv
// Self-checking bench: full sweep of {0,1,64,127} over eight candidates,
// then pseudo-random sets; expected ranking by repeated maximum search.
module mu_top3_select_test;
    localparam int NQ    = 4;
    localparam int NC    = 8;
    localparam int BXW   = 12;
    localparam int LAT   = 4;
    localparam int NSWP  = 65536;
    localparam int NRND  = 3000;
    localparam int TOTAL = NSWP + NRND;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [BXW-1:0] in_bx = '0;
    logic [55:0]   in_pt = '0;
    logic [47:0]   in_addr = '0;
    logic          out_valid;
    logic [BXW-1:0] out_bx;
    logic [20:0]   out_pt;
    logic [8:0]    out_idx;
    logic [17:0]   out_addr;
    logic [7:0]    out_sum;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    // Expected-result ring indexed by input cycle modulo 8.
    logic        e_v    [8];
    logic [11:0] e_bx   [8];
    logic [20:0] e_pt   [8];
    logic [8:0]  e_idx  [8];
    logic [17:0] e_addr [8];
    logic [7:0]  e_sum  [8];

    mu_top3_select #(.N_QUAD(NQ), .BX_W(BXW)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bx(in_bx),
        .in_pt(in_pt), .in_addr(in_addr), .out_valid(out_valid), .out_bx(out_bx),
        .out_pt(out_pt), .out_idx(out_idx), .out_addr(out_addr), .out_sum(out_sum)
    );

    always #2 clk = ~clk;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic logic [6:0] dmap(input int d);
        case (d)
            0: return 7'd0;
            1: return 7'd1;
            2: return 7'd64;
            default: return 7'd127;
        endcase
    endfunction

    // Build the expected result for one set and store it in slot c%8.
    task automatic make_expect(input int c, input logic v, input logic [55:0] pt, input logic [47:0] ad);
        bit used [NC];
        int sl;
        sl = c % 8;
        for (int k = 0; k < NC; k++) used[k] = 1'b0;
        e_v[sl]  = v;
        e_bx[sl] = BXW'(c);
        for (int s = 0; s < 3; s++) begin
            int best;
            best = -1;
            for (int k = 0; k < NC; k++)
                if (!used[k] && (best < 0 || pt[k*7 +: 7] > pt[best*7 +: 7])) best = k;
            used[best] = 1'b1;
            e_pt[sl][s*7 +: 7]   = pt[best*7 +: 7];
            e_idx[sl][s*3 +: 3]  = 3'(best);
            e_addr[sl][s*6 +: 6] = ad[best*6 +: 6];
        end
        e_sum[sl] = 8'(e_pt[sl][6:0]) + 8'(e_pt[sl][13:7]);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired, actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr;
        lfsr = 32'h1357_9bdf;
        // R1: reset with busy inputs must leave the outputs clear.
        @(negedge clk);
        in_valid = 1'b1;
        in_pt    = {8{7'h55}};
        in_addr  = {8{6'h2a}};
        repeat (3) @(negedge clk);
        chk("R1", "out_valid in reset", 32'(out_valid), 0);
        chk("R1", "out_pt in reset", 32'(out_pt), 0);
        chk("R1", "out_sum in reset", 32'(out_sum), 0);
        rst_n = 1'b1;

        for (int c = 0; c < TOTAL + LAT; c++) begin
            if (c > 0) @(negedge clk);
            // Sample outputs belonging to the set driven LAT cycles earlier.
            if (c < LAT) begin
                chk("R1", "no result before pipeline fills", 32'(out_valid), 0);
            end else begin
                int sl;
                sl = (c - LAT) % 8;
                chk("R7", "out_valid", 32'(out_valid), 32'(e_v[sl]));
                if (e_v[sl]) begin
                    chk("R6", "out_bx", 32'(out_bx), 32'(e_bx[sl]));
                    chk("R2", "slot0 pt", 32'(out_pt[6:0]), 32'(e_pt[sl][6:0]));
                    chk("R3", "slot1/2 pt", 32'(out_pt[20:7]), 32'(e_pt[sl][20:7]));
                    chk("R4", "positions", 32'(out_idx), 32'(e_idx[sl]));
                    chk("R8", "addresses", 32'(out_addr), 32'(e_addr[sl]));
                    chk("R5", "sum", 32'(out_sum), 32'(e_sum[sl]));
                end
            end
            // Drive the next set.
            if (c < TOTAL) begin
                logic [55:0] pt;
                logic [47:0] ad;
                for (int k = 0; k < NC; k++) begin
                    if (c < NSWP) begin
                        pt[k*7 +: 7] = dmap((c >> (2*k)) & 3);
                    end else begin
                        lfsr = lfsr ^ (lfsr << 13);
                        lfsr = lfsr ^ (lfsr >> 17);
                        lfsr = lfsr ^ (lfsr << 5);
                        pt[k*7 +: 7] = lfsr[6:0] & ((c % 3 == 0) ? 7'h03 : ((c % 3 == 1) ? 7'h0f : 7'h7f));
                    end
                    ad[k*6 +: 6] = 6'((c * 5 + k * 11) & 63);
                end
                in_valid = ((c % 53) != 17);
                in_bx    = BXW'(c);
                in_pt    = pt;
                in_addr  = ad;
                make_expect(c, in_valid, pt, ad);
            end else begin
                in_valid = 1'b0;
                make_expect(c, 1'b0, '0, '0);
            end
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule